// File: doc/BRIEF.md
# Double-Edge Strobe Read Capture

This block is the receive half of an octal serial flash controller's data path. While a command or address is being sent, it drives the 8-bit data lines from a registered command byte. It releases them for the data phase. Once a read is started, bytes from the device are latched on both edges of a strobe that has already been delayed into the data eye. They go into a small dual-clock FIFO. The reference-clock side then unloads them as a byte stream with a valid flag.

Unloading begins in a programmable target cycle. A 4-bit read-delay value pushes that cycle later by whole reference cycles, so a round trip longer than one clock period still lines up. If no byte is waiting when one is due, a sticky error flag is raised and the transfer is dropped. The transfer length is given in bytes. The capture side stops writing once that many bytes are stored, and any further strobe edges are discarded.

Bytes are packed in pairs: the rising-edge byte and the following falling-edge byte form one FIFO entry. Pointers cross the clock boundary as Gray codes through two-flop synchronizers.

Top module: `strobe_rx_capture`

## Requirements
- R1: While no transfer is active and `drive_i` is high, `dq_oe_o` is high after the next rising edge of `clk_i`. `dq_o` carries the value `cmd_byte_i` had at that edge.
- R2: `start_i` is accepted only when no transfer is active and `dq_oe_o` is already low, which gives at least one turnaround cycle. A `start_i` seen while `dq_oe_o` is high is ignored. `dq_oe_o` stays low for the whole of an accepted transfer, whatever `drive_i` does.
- R3: The byte presented on a rising edge of `dqs_dly_i` is delivered first, followed by the byte presented on the next falling edge. Bytes leave on `rdata_o` in the order they arrived.
- R4: Call the `clk_i` edge that samples an accepted `start_i` edge 0, and let D be `rd_delay_i` (0 to 15). The first byte is valid on `rvalid_o` after edge D+1.
- R5: Each remaining byte is valid after the next edge, on consecutive cycles. Exactly `byte_count_i` bytes (1 to 16) are delivered.
- R6: Strobe edges beyond `byte_count_i` bytes (rounded up to whole rising/falling pairs) are not stored. They do not alter the data of the next transfer.
- R7: If the FIFO is empty on the edge where a byte is due, `cap_err_o` becomes 1 after that edge, the transfer ends, and no further byte is delivered.
- R8: `cap_err_o` holds its value until `err_clr_i` is high at a rising edge, which clears it. If a new miss occurs on the same edge, the set takes priority over the clear.
- R9: During reset `dq_oe_o`, `rvalid_o` and `cap_err_o` are 0.
- R10: Bytes left in the FIFO by an ended or aborted transfer are discarded before the next transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drive_i | input | 1 | Request to drive the data lines (command/address phase) |
| cmd_byte_i | input | 8 | Byte to drive while driving |
| start_i | input | 1 | Begin a read data phase |
| rd_delay_i | input | 4 | Target-cycle delay in reference cycles; held during a transfer |
| byte_count_i | input | 5 | Transfer length in bytes, 1 to 16; held during a transfer |
| dqs_dly_i | input | 1 | Delayed data strobe from the device |
| dq_i | input | 8 | Data lines, input side |
| dq_o | output | 8 | Data lines, output side |
| dq_oe_o | output | 1 | Output enable for the data lines |
| rdata_o | output | 8 | Unloaded byte |
| rvalid_o | output | 1 | `rdata_o` holds a valid byte |
| cap_err_o | output | 1 | Sticky missed-byte flag |
| err_clr_i | input | 1 | Write-one clear for `cap_err_o` |

## Verification
Every result is registered on `clk_i`, so the bench samples on falling edges and counts rising edges from the one that sampled start. Byte k of a transfer must appear when that count equals D+1+k: the first byte tests the target cycle and the rest test back-to-back delivery. The drive-enable and command-byte outputs are checked one edge after their inputs change, and the error flag one edge after the due edge on which the FIFO was empty. The bench places strobe pairs so that a written pair passes through the two synchronizer stages in time for the chosen delay, or, in the error case, deliberately too late.

// File: rtl/strobe_cap_pkg.sv
`timescale 1ns/1ps
package strobe_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_UNLOAD
  } rd_state_e;
endpackage

// File: rtl/strobe_cap_sync.sv
`timescale 1ns/1ps
module strobe_cap_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/strobe_cap_wr.sv
`timescale 1ns/1ps
module strobe_cap_wr #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 5
) (
  input  logic                dqs_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic [DATA_W-1:0]   dq_i,
  input  logic [CNT_W-1:0]    pair_lim_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [ADDR_W:0]     wr_gray_o,
  output logic [2*DATA_W-1:0] rd_word_o
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [2*DATA_W-1:0] mem_q [ENTRIES];
  logic [DATA_W-1:0]   rise_q;
  logic [CNT_W-1:0]    pair_cnt_q;
  logic [ADDR_W:0]     wr_bin_q, wr_bin_nxt;
  logic                clr_n, wr_en;

  // pair counter is held clear whenever no transfer is armed
  assign clr_n      = rst_ni & arm_i;
  assign wr_en      = arm_i && (pair_cnt_q < pair_lim_i);
  assign wr_bin_nxt = wr_bin_q + 1'b1;

  always_ff @(posedge dqs_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= dq_i;
  end

  always_ff @(negedge dqs_i or negedge clr_n) begin
    if (!clr_n)     pair_cnt_q <= '0;
    else if (wr_en) pair_cnt_q <= pair_cnt_q + 1'b1;
  end

  always_ff @(negedge dqs_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bin_q  <= '0;
      wr_gray_o <= '0;
    end else if (wr_en) begin
      wr_bin_q  <= wr_bin_nxt;
      wr_gray_o <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
    end
  end

  always_ff @(negedge dqs_i) begin
    if (wr_en) mem_q[wr_bin_q[ADDR_W-1:0]] <= {rise_q, dq_i};
  end

  assign rd_word_o = mem_q[rd_addr_i];
endmodule

// File: rtl/strobe_cap_rd.sv
`timescale 1ns/1ps
module strobe_cap_rd
  import strobe_cap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 5,
  parameter int DLY_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_ok_i,
  input  logic [DLY_W-1:0]    rd_delay_i,
  input  logic [CNT_W-1:0]    byte_count_i,
  input  logic                err_clr_i,
  input  logic [ADDR_W:0]     wr_gray_i,
  input  logic [2*DATA_W-1:0] rd_word_i,
  output logic                busy_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o,
  output logic                cap_err_o
);
  rd_state_e        state_q;
  logic [DLY_W-1:0] cyc_q;
  logic [CNT_W-1:0] left_q;
  logic             half_q;
  logic [ADDR_W:0]  rd_bin_q, wr_bin_s;
  logic             avail, due, hit, miss;
  logic [DATA_W-1:0] byte_sel;

  always_comb begin
    wr_bin_s[ADDR_W] = wr_gray_i[ADDR_W];
    for (int i = ADDR_W - 1; i >= 0; i--) wr_bin_s[i] = wr_bin_s[i+1] ^ wr_gray_i[i];
  end

  assign avail    = (rd_bin_q != wr_bin_s);
  assign due      = (state_q == ST_WAIT && cyc_q == rd_delay_i) || (state_q == ST_UNLOAD);
  assign hit      = due && avail;
  assign miss     = due && !avail;
  assign byte_sel = half_q ? rd_word_i[DATA_W-1:0] : rd_word_i[2*DATA_W-1:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cyc_q     <= '0;
      left_q    <= '0;
      half_q    <= 1'b0;
      rd_bin_q  <= '0;
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
      cap_err_o <= 1'b0;
    end else begin
      rvalid_o  <= hit;
      cap_err_o <= miss | (cap_err_o & ~err_clr_i);
      if (hit) rdata_o <= byte_sel;
      if (state_q == ST_IDLE) begin
        // drop anything still arriving from an earlier transfer
        rd_bin_q <= wr_bin_s;
        half_q   <= 1'b0;
        if (start_ok_i) begin
          state_q <= ST_WAIT;
          cyc_q   <= '0;
          left_q  <= byte_count_i;
        end
      end else begin
        if (state_q == ST_WAIT && !due) cyc_q <= cyc_q + 1'b1;
        if (miss) begin
          state_q <= ST_IDLE;
        end else if (hit) begin
          half_q <= ~half_q;
          if (half_q) rd_bin_q <= rd_bin_q + 1'b1;
          left_q  <= left_q - 1'b1;
          state_q <= (left_q == CNT_W'(1)) ? ST_IDLE : ST_UNLOAD;
        end
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign rd_addr_o = rd_bin_q[ADDR_W-1:0];
endmodule

// File: rtl/strobe_rx_capture.sv
`timescale 1ns/1ps
module strobe_rx_capture #(
  parameter int DATA_W      = 8,
  parameter int DEPTH_BYTES = 16,
  parameter int DLY_W       = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        drive_i,
  input  logic [DATA_W-1:0]           cmd_byte_i,
  input  logic                        start_i,
  input  logic [DLY_W-1:0]            rd_delay_i,
  input  logic [$clog2(DEPTH_BYTES+1)-1:0] byte_count_i,
  input  logic                        dqs_dly_i,
  input  logic [DATA_W-1:0]           dq_i,
  output logic [DATA_W-1:0]           dq_o,
  output logic                        dq_oe_o,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        rvalid_o,
  output logic                        cap_err_o,
  input  logic                        err_clr_i
);
  localparam int ENTRIES = DEPTH_BYTES / 2;
  localparam int ADDR_W  = $clog2(ENTRIES);
  localparam int CNT_W   = $clog2(DEPTH_BYTES + 1);

  logic                busy, start_ok;
  logic [CNT_W-1:0]    pair_lim;
  logic [ADDR_W:0]     wr_gray, wr_gray_s;
  logic [ADDR_W-1:0]   rd_addr;
  logic [2*DATA_W-1:0] rd_word;

  // a start is only taken once the bus has already been released
  assign start_ok = start_i && !busy && !dq_oe_o;
  assign pair_lim = CNT_W'(({1'b0, byte_count_i} + 1'b1) >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_oe_o <= 1'b0;
      dq_o    <= '0;
    end else begin
      dq_oe_o <= drive_i && !busy && !start_ok;
      if (drive_i) dq_o <= cmd_byte_i;
    end
  end

  strobe_cap_wr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wr (
    .dqs_i     (dqs_dly_i),
    .rst_ni    (rst_ni),
    .arm_i     (busy),
    .dq_i      (dq_i),
    .pair_lim_i(pair_lim),
    .rd_addr_i (rd_addr),
    .wr_gray_o (wr_gray),
    .rd_word_o (rd_word)
  );

  strobe_cap_sync #(.W(ADDR_W + 1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_gray),
    .q_o   (wr_gray_s)
  );

  strobe_cap_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_ok_i  (start_ok),
    .rd_delay_i  (rd_delay_i),
    .byte_count_i(byte_count_i),
    .err_clr_i   (err_clr_i),
    .wr_gray_i   (wr_gray_s),
    .rd_word_i   (rd_word),
    .busy_o      (busy),
    .rd_addr_o   (rd_addr),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .cap_err_o   (cap_err_o)
  );
endmodule

// File: rtl/strobe_cap_chk.sv
`timescale 1ns/1ps
module strobe_cap_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             dq_oe_i,
  input logic             rvalid_i,
  input logic             cap_err_i,
  input logic             err_clr_i,
  input logic [CNT_W-1:0] byte_count_i
);
  logic             busy_d_q;
  logic [CNT_W:0]   seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_d_q <= 1'b0;
      seen_q   <= '0;
    end else begin
      busy_d_q <= busy_i;
      if (busy_i && !busy_d_q) seen_q <= '0;
      else if (rvalid_i)       seen_q <= seen_q + 1'b1;
    end
  end

  assert_oe_off_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !dq_oe_i);

  assert_turnaround_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(!dq_oe_i));

  assert_no_early_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !rvalid_i);

  assert_byte_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_i && busy_d_q == busy_d_q) |-> (seen_q < {1'b0, byte_count_i}));

  assert_miss_no_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_err_i) |-> !rvalid_i);

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_err_i && !err_clr_i) |=> cap_err_i);
endmodule

bind strobe_rx_capture strobe_cap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy),
  .dq_oe_i     (dq_oe_o),
  .rvalid_i    (rvalid_o),
  .cap_err_i   (cap_err_o),
  .err_clr_i   (err_clr_i),
  .byte_count_i(byte_count_i)
);

// File: tb/strobe_rx_capture_tb.sv
`timescale 1ns/1ps
module strobe_rx_capture_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       drive = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       start = 1'b0;
  logic [3:0] rd_delay = '0;
  logic [4:0] byte_count = 5'd1;
  logic       dqs = 1'b0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic       dq_oe;
  logic [7:0] rdata;
  logic       rvalid;
  logic       cap_err;
  logic       err_clr = 1'b0;

  int checks = 0;
  int failures = 0;
  int edge_cnt = 0;
  int start_edge = 0;
  int exp_first = 0;
  int idx = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  strobe_rx_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .drive_i(drive), .cmd_byte_i(cmd_byte),
    .start_i(start), .rd_delay_i(rd_delay), .byte_count_i(byte_count),
    .dqs_dly_i(dqs), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe),
    .rdata_o(rdata), .rvalid_o(rvalid), .cap_err_o(cap_err), .err_clr_i(err_clr)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) edge_cnt++;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 or R7 unexpected byte", rdata, 0);
      end else begin
        logic [7:0] b;
        b = exp_q.pop_front();
        check(rdata == b, "R3 byte order", rdata, b);
        check(edge_cnt - start_edge == exp_first + idx, (idx == 0) ? "R4 first byte cycle" : "R5 next byte cycle",
              edge_cnt - start_edge, exp_first + idx);
        idx++;
      end
    end
  end

  task automatic xfer(int d, int n, int lat, int pairs, int base, bit good);
    rd_delay   = 4'(d);
    byte_count = 5'(n);
    idx        = 0;
    exp_first  = d + 1;
    if (good) for (int i = 0; i < n; i++) exp_q.push_back(8'(base + i));
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    #0.5 start_edge = edge_cnt;
    start = 1'b0;
    #0.75;
    repeat (lat) #5;
    for (int p = 0; p < pairs; p++) begin
      dq_in = 8'(base + 2 * p);
      #1 dqs = 1'b1;
      #4 dq_in = 8'(base + 2 * p + 1);
      #1 dqs = 1'b0;
      #4;
    end
    repeat (d + n + 12) @(posedge clk);
    @(negedge clk);
    if (good) check(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(dq_oe == 1'b0, "R9 reset oe", dq_oe, 0);
    check(rvalid == 1'b0, "R9 reset valid", rvalid, 0);
    check(cap_err == 1'b0, "R9 reset error", cap_err, 0);
    @(negedge clk) rst_n = 1'b1;

    // R1 command drive
    @(negedge clk) begin drive = 1'b1; cmd_byte = 8'hA5; end
    @(negedge clk);
    check(dq_oe == 1'b1, "R1 oe on", dq_oe, 1);
    check(dq_out == 8'hA5, "R1 cmd byte", dq_out, 8'hA5);
    cmd_byte = 8'h3C;
    @(negedge clk);
    check(dq_out == 8'h3C, "R1 cmd byte follow", dq_out, 8'h3C);

    // R2 start while still driving is ignored
    rd_delay = 4'd0;
    byte_count = 5'd4;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    check(cap_err == 1'b0, "R2 start ignored no error", cap_err, 0);
    check(dq_oe == 1'b1, "R2 start ignored oe kept", dq_oe, 1);
    drive = 1'b0;
    repeat (3) @(negedge clk);
    check(dq_oe == 1'b0, "R1 oe off", dq_oe, 0);

    xfer(3, 8, 0, 4, 8'h10, 1'b1);

    fork
      xfer(7, 16, 3, 8, 8'h40, 1'b1);
      begin
        repeat (4) @(posedge clk);
        #1 drive = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(dq_oe == 1'b0, "R2 oe low in transfer", dq_oe, 0);
        drive = 1'b0;
      end
    join

    xfer(15, 3, 0, 2, 8'h70, 1'b1);

    // R6 extra strobe pairs beyond the count
    xfer(4, 5, 0, 5, 8'h80, 1'b1);

    // R7 target cycle too early
    xfer(1, 4, 0, 2, 8'hC0, 1'b0);
    check(cap_err == 1'b1, "R7 miss flagged", cap_err, 1);
    repeat (5) @(negedge clk);
    check(cap_err == 1'b1, "R8 flag sticky", cap_err, 1);
    err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    check(cap_err == 1'b0, "R8 flag cleared", cap_err, 0);

    // R10 leftovers from aborted and over-long transfers must not appear
    xfer(3, 6, 0, 3, 8'hE0, 1'b1);
    check(cap_err == 1'b0, "R10 clean transfer no error", cap_err, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule